// File: doc/BRIEF.md
# Regex Configuration Image Loader

This block pulls a packed configuration image, built from 64-bit words, out of a memory through a simple read port. It then spreads the image over the two local memories of a regular-expression matching engine. The image opens with a two-word header. The first header word gives the length of the whole image. The second gives the number of program words, the number of character classes and the number of capture groups. The program words come next and go to the instruction memory. The character-class bit maps come last and go to the class memory.

A controller pulses `start` once the image sits in memory. The loader then reads the image from address 0, one word at a time. It writes each payload word through a write port that the memory can take directly, with no extra stage. It publishes the three counts as soon as the second header word has arrived. A length that does not agree with the counts stops the load with an error flag. A load that completes ends with a steady done flag that the matcher can wait on.

Top module: `cfgld_top`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `rd_req`, both write enables and all three count outputs are 0.
- R2: A `start` pulse while the loader is idle or done begins a load. In the next cycle `busy` is 1, `done`, `error` and the counts are 0, and the first read asks for address 0.
- R3: Word 0 of the image is the total word count, headers included. In word 1, bits [31:0] are the instruction count, bits [47:32] the class count and bits [63:48] the group count. These appear on `instr_count`, `class_count` and `group_count` in the cycle after word 1 is accepted.
- R4: Image word k, for 2 <= k < 2+N with N the instruction count, is written unchanged to the instruction memory at address k-2. The write is visible on the write port in the same cycle that `rd_valid` returns it.
- R5: Each class takes 4 image words (256 bits, one per byte value). Each word holds two 32-bit entries, the lower-indexed one in bits [31:0]. Word k, for 2+N <= k < 2+N+4C, is written unchanged to the class memory at address k-2-N in the cycle `rd_valid` returns it.
- R6: At most one read is outstanding. Addresses go up by one from 0. After a request, no new request is made until `rd_valid` has returned that word, whatever the latency (at least one cycle).
- R7: One cycle after the last image word is accepted, `busy` goes to 0 and `done` goes to 1. `done` stays 1 until the next accepted `start`.
- R8: If word 0 differs from 2 + N + 4·C, `error` goes to 1 one cycle after word 1 is accepted. No further read or write follows, `done` stays 0, and `error` holds until the next accepted `start`.
- R9: With C = 0 the load ends after the instructions and the class memory is never written. With N = 0 the class words follow the header directly. With both zero and word 0 equal to 2, the load ends right after the header.
- R10: A `start` pulse while a load is in progress is ignored. The load in progress carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that begins a load |
| rd_req | output | 1 | Read request, one cycle per word |
| rd_addr | output | AW | Word address of the request |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Returned image word |
| instr_we | output | 1 | Instruction memory write enable |
| instr_addr | output | IAW | Instruction memory write address |
| instr_wdata | output | 64 | Instruction memory write data |
| cls_we | output | 1 | Class memory write enable |
| cls_addr | output | BAW | Class memory write address |
| cls_wdata | output | 64 | Class memory write data |
| instr_count | output | 32 | Instruction count from the header |
| class_count | output | 16 | Character-class count from the header |
| group_count | output | 16 | Capture-group count from the header |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed |
| error | output | 1 | Header length mismatch |

## Verification
The hardest cases to reach are the ones where one word closes two phases at once: the last instruction, or the header itself, ending a load that has no class words or no words at all. A state that goes wrong there skips a phase or writes a stray word. The stimulus builds images with zero classes, zero instructions, both zero, and a length off by one. It returns each word after a random delay, so phase changes fall at many different spacings. A second `start` is also sent in the middle of a load to confirm that it has no effect.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int WORD_W    = 64;
    localparam int CLS_WORDS = 4;
    localparam int HDR_WORDS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR0,
        ST_HDR1,
        ST_INSTR,
        ST_BITSET,
        ST_DONE
    } ld_state_e;

    // Second header word, most significant field first
    typedef struct packed {
        logic [15:0] grp;
        logic [15:0] cls;
        logic [31:0] instr;
    } cfg_hdr_t;

    function automatic logic [WORD_W-1:0] blocks_expected(cfg_hdr_t h);
        return 64'(HDR_WORDS) + {32'd0, h.instr} + {46'd0, h.cls, 2'b00};
    endfunction

    function automatic logic is_loading(ld_state_e s);
        return (s == ST_HDR0) || (s == ST_HDR1) || (s == ST_INSTR) || (s == ST_BITSET);
    endfunction

endpackage

// File: rtl/cfgld_reader.sv
module cfgld_reader #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          fetch_en,
    input  logic          rd_valid,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          word_take
);
    logic          pending;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pending <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (rd_req) begin
                pending <= 1'b1;
            end
            if (word_take) begin
                pending <= 1'b0;
                addr_q  <= addr_q + AW'(1);
            end
        end
    end

    always_comb begin
        rd_req    = fetch_en && !pending && !restart;
        rd_addr   = addr_q;
        word_take = pending && rd_valid && fetch_en;
    end

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              word_take,
    input  logic [WORD_W-1:0] word_data,
    output ld_state_e         state,
    output cfg_hdr_t          hdr,
    output logic              restart,
    output logic              busy,
    output logic              done,
    output logic              error
);
    logic [WORD_W-1:0] total_q;
    logic [31:0]       icnt_q;
    logic [17:0]       bcnt_q;
    logic              err_q;
    cfg_hdr_t          in_hdr;

    always_comb begin
        in_hdr  = cfg_hdr_t'(word_data);
        restart = start && ((state == ST_IDLE) || (state == ST_DONE));
        busy    = is_loading(state);
        done    = (state == ST_DONE);
        error   = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            hdr     <= '0;
            total_q <= '0;
            icnt_q  <= '0;
            bcnt_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (restart) begin
                        state   <= ST_HDR0;
                        hdr     <= '0;
                        total_q <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_HDR0: begin
                    if (word_take) begin
                        total_q <= word_data;
                        state   <= ST_HDR1;
                    end
                end
                ST_HDR1: begin
                    if (word_take) begin
                        hdr <= in_hdr;
                        if (total_q != blocks_expected(in_hdr)) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else if (in_hdr.instr != '0) begin
                            icnt_q <= in_hdr.instr;
                            state  <= ST_INSTR;
                        end else if (in_hdr.cls != '0) begin
                            bcnt_q <= {in_hdr.cls, 2'b00};
                            state  <= ST_BITSET;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_INSTR: begin
                    if (word_take) begin
                        icnt_q <= icnt_q - 32'd1;
                        if (icnt_q == 32'd1) begin
                            if (hdr.cls != '0) begin
                                bcnt_q <= {hdr.cls, 2'b00};
                                state  <= ST_BITSET;
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                ST_BITSET: begin
                    if (word_take) begin
                        bcnt_q <= bcnt_q - 18'd1;
                        if (bcnt_q == 18'd1) begin
                            state <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgld_router.sv
module cfgld_router
    import cfgld_pkg::*;
#(
    parameter int AW  = 16,
    parameter int IAW = 8,
    parameter int BAW = 8
) (
    input  ld_state_e         state,
    input  logic [31:0]       n_instr,
    input  logic              word_take,
    input  logic [AW-1:0]     word_idx,
    input  logic [WORD_W-1:0] word_data,
    output logic              instr_we,
    output logic [IAW-1:0]    instr_addr,
    output logic [WORD_W-1:0] instr_wdata,
    output logic              cls_we,
    output logic [BAW-1:0]    cls_addr,
    output logic [WORD_W-1:0] cls_wdata
);
    logic [AW-1:0] pay_off;
    logic [AW-1:0] cls_off;

    always_comb begin
        pay_off     = word_idx - AW'(HDR_WORDS);
        cls_off     = pay_off - AW'(n_instr);
        instr_we    = word_take && (state == ST_INSTR);
        cls_we      = word_take && (state == ST_BITSET);
        instr_addr  = IAW'(pay_off);
        cls_addr    = BAW'(cls_off);
        instr_wdata = word_data;
        cls_wdata   = word_data;
    end

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int AW  = 16,
    parameter int IAW = 8,
    parameter int BAW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_valid,
    input  logic [63:0]    rd_data,
    output logic           instr_we,
    output logic [IAW-1:0] instr_addr,
    output logic [63:0]    instr_wdata,
    output logic           cls_we,
    output logic [BAW-1:0] cls_addr,
    output logic [63:0]    cls_wdata,
    output logic [31:0]    instr_count,
    output logic [15:0]    class_count,
    output logic [15:0]    group_count,
    output logic           busy,
    output logic           done,
    output logic           error
);
    ld_state_e state;
    cfg_hdr_t  hdr;
    logic      restart;
    logic      word_take;

    cfgld_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .word_take (word_take),
        .word_data (rd_data),
        .state     (state),
        .hdr       (hdr),
        .restart   (restart),
        .busy      (busy),
        .done      (done),
        .error     (error)
    );

    cfgld_reader #(.AW(AW)) u_reader (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .fetch_en  (busy),
        .rd_valid  (rd_valid),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .word_take (word_take)
    );

    cfgld_router #(.AW(AW), .IAW(IAW), .BAW(BAW)) u_router (
        .state       (state),
        .n_instr     (hdr.instr),
        .word_take   (word_take),
        .word_idx    (rd_addr),
        .word_data   (rd_data),
        .instr_we    (instr_we),
        .instr_addr  (instr_addr),
        .instr_wdata (instr_wdata),
        .cls_we      (cls_we),
        .cls_addr    (cls_addr),
        .cls_wdata   (cls_wdata)
    );

    always_comb begin
        instr_count = hdr.instr;
        class_count = hdr.cls;
        group_count = hdr.grp;
    end

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic rd_req,
    input logic rd_valid,
    input logic instr_we,
    input logic cls_we,
    input logic busy,
    input logic done,
    input logic error
);
    // R6
    single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R4
    instr_write_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        instr_we |-> rd_valid);

    // R5
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        !(instr_we && cls_we));

    // R7
    done_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(rd_valid));

    // R8
    error_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> $past(rd_valid));

    // R8
    error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(error) |-> $past(start));

    // R7
    done_error_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R2
    start_begins_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind cfgld_top cfgld_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .instr_we (instr_we),
    .cls_we   (cls_we),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/sim_cfgld_top.sv
module sim_cfgld_top;
    localparam int AW = 16;
    localparam int IAW = 8;
    localparam int BAW = 8;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic rd_req;
    logic [AW-1:0] rd_addr;
    logic rd_valid = 0;
    logic [63:0] rd_data = '0;
    logic instr_we, cls_we;
    logic [IAW-1:0] instr_addr;
    logic [BAW-1:0] cls_addr;
    logic [63:0] instr_wdata, cls_wdata;
    logic [31:0] instr_count;
    logic [15:0] class_count, group_count;
    logic busy, done, error;

    always #10 clk = ~clk;

    cfgld_top #(.AW(AW), .IAW(IAW), .BAW(BAW)) u0 (.*);

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Memory image and read responder
    logic [63:0] img [0:127];
    int lat_mode = 0;
    int wait_cnt = 0;
    int addr_l = 0;

    // Reference model state
    bit active = 0;
    int k = 0;
    logic [63:0] m_tot = '0;
    logic [31:0] m_n = '0;
    logic [15:0] m_c = '0, m_g = '0;
    bit m_done = 0, m_err = 0;

    // Shadow memories filled from the write ports
    logic [63:0] sh_i [0:255];
    logic [63:0] sh_c [0:255];
    int wr_i = 0, wr_c = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            active = 0; k = 0; m_done = 0; m_err = 0;
            m_n = '0; m_c = '0; m_g = '0; m_tot = '0;
        end else if (start && !active) begin
            active = 1; k = 0; m_done = 0; m_err = 0;
            m_n = '0; m_c = '0; m_g = '0; m_tot = '0;
        end else if (active && rd_valid) begin
            if (k == 0) m_tot = rd_data;
            else if (k == 1) begin
                m_n = rd_data[31:0]; m_c = rd_data[47:32]; m_g = rd_data[63:48];
                if (m_tot != 64'd2 + 64'(m_n) + 64'(m_c) * 64'd4) begin m_err = 1; active = 0; end
                else if (m_tot == 64'd2) begin m_done = 1; active = 0; end
            end else if (64'(k) == m_tot - 64'd1) begin m_done = 1; active = 0; end
            k++;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 0;
            rd_data = '0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin rd_valid = 1; rd_data = img[addr_l % 128]; end
            end
            if (rd_req) begin
                addr_l = int'(rd_addr);
                wait_cnt = (lat_mode == 0) ? 1 : 1 + int'($urandom % 4);
            end
            #5;
            if (!rst) begin
                bit e_i, e_c;
                e_i = 0; e_c = 0;
                if (active && rd_valid && k >= 2) begin
                    if (k < 2 + int'(m_n)) e_i = 1; else e_c = 1;
                end
                chk(busy == active, "R7 busy", 64'(busy), 64'(active));
                chk(done == m_done, "R7 done", 64'(done), 64'(m_done));
                chk(error == m_err, "R8 error", 64'(error), 64'(m_err));
                chk({group_count, class_count, instr_count} == {m_g, m_c, m_n}, "R3 counts",
                    {group_count, class_count, instr_count}, {m_g, m_c, m_n});
                if (rd_req) chk(int'(rd_addr) == k, "R6 address", 64'(rd_addr), 64'(k));
                chk(instr_we == e_i, "R4 instr_we", 64'(instr_we), 64'(e_i));
                chk(cls_we == e_c, "R5 cls_we", 64'(cls_we), 64'(e_c));
                if (e_i && instr_we) begin
                    chk(int'(instr_addr) == (k - 2) % 256, "R4 instr_addr", 64'(instr_addr), 64'(k - 2));
                    chk(instr_wdata == rd_data, "R4 instr_wdata", instr_wdata, rd_data);
                end
                if (e_c && cls_we) begin
                    chk(int'(cls_addr) == (k - 2 - int'(m_n)) % 256, "R5 cls_addr",
                        64'(cls_addr), 64'(k - 2 - int'(m_n)));
                    chk(cls_wdata == rd_data, "R5 cls_wdata", cls_wdata, rd_data);
                end
                if (instr_we) begin sh_i[instr_addr] = instr_wdata; wr_i++; end
                if (cls_we) begin sh_c[cls_addr] = cls_wdata; wr_c++; end
            end
        end
    end

    task automatic build(input int n, input int c, input int g, input int skew);
        img[0] = 64'(2 + n + 4 * c + skew);
        img[1] = {16'(g), 16'(c), 32'(n)};
        for (int i = 2; i < 128; i++) img[i] = {$urandom, $urandom};
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (!(done || error) && t < 3000) begin @(negedge clk); t++; end
        chk(t < 3000, "R7 load finishes", 64'(t), 64'd3000);
        @(negedge clk);
    endtask

    task automatic run(input int n, input int c, input int g, input int skew, input int lm, input string tag);
        build(n, c, g, skew);
        lat_mode = lm;
        wr_i = 0; wr_c = 0;
        pulse_start();
        wait_end();
        if (skew == 0) begin
            chk(done && !error, {tag, " done"}, 64'({done, error}), 64'b10);
            chk(wr_i == n, {tag, " instr writes"}, 64'(wr_i), 64'(n));
            chk(wr_c == 4 * c, {tag, " class writes"}, 64'(wr_c), 64'(4 * c));
            for (int i = 0; i < n; i++)
                chk(sh_i[i] == img[2 + i], {tag, " instr RAM"}, sh_i[i], img[2 + i]);
            for (int i = 0; i < 4 * c; i++)
                chk(sh_c[i] == img[2 + n + i], {tag, " class RAM"}, sh_c[i], img[2 + n + i]);
        end else begin
            chk(error && !done, {tag, " error"}, 64'({done, error}), 64'b01);
            chk(wr_i == 0 && wr_c == 0, {tag, " no writes"}, 64'(wr_i + wr_c), 64'd0);
            repeat (5) @(negedge clk);
            chk(!rd_req && !busy && error, {tag, " stays stopped"}, 64'({rd_req, busy, error}), 64'b001);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, error, rd_req, instr_we, cls_we} == 6'b0, "R1 reset flags",
            64'({busy, done, error, rd_req, instr_we, cls_we}), 64'd0);
        chk({instr_count, class_count, group_count} == 64'd0, "R1 reset counts",
            {instr_count, class_count, group_count}, 64'd0);

        // R2 start begins load, reads address 0
        build(5, 2, 3, 0);
        lat_mode = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy && rd_req && rd_addr == 0, "R2 start", 64'({busy, rd_req, rd_addr}), 64'b11 << AW);
        wr_i = 0; wr_c = 0;
        wait_end();
        chk(done && wr_i == 5 && wr_c == 8, "R2 first load", 64'(wr_i + wr_c), 64'd13);

        run(5, 2, 3, 0, 1, "R4 R5 random latency");
        run(12, 3, 1, 0, 1, "R3 larger image");
        run(3, 0, 2, 0, 1, "R9 zero classes");
        run(0, 2, 0, 0, 1, "R9 zero instructions");
        run(0, 0, 0, 0, 0, "R9 empty payload");
        run(4, 1, 0, 1, 1, "R8 length too long");
        run(4, 1, 0, -1, 0, "R8 length too short");
        run(1, 1, 0, 0, 0, "R2 restart after error");

        // R10 start during a load is ignored
        build(6, 2, 5, 0);
        lat_mode = 1;
        wr_i = 0; wr_c = 0;
        pulse_start();
        repeat (7) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy, "R10 still busy", 64'(busy), 64'd1);
        wait_end();
        chk(done && wr_i == 6 && wr_c == 8, "R10 load unchanged", 64'(wr_i + wr_c), 64'd14);

        // R7 done holds without start
        repeat (10) @(negedge clk);
        chk(done && !busy && !rd_req, "R7 done holds", 64'({done, busy, rd_req}), 64'b100);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule